// File: doc/BRIEF.md
# MDIO Management Controller with Single User-Access Channel

This block is a register-driven management master for Clause 22 PHY access. Software first writes a control register to enable the controller and to set the management clock divider. It then writes one user-access word that carries a command bit, a read/write select, a PHY address, a register number and, for writes, the data. The controller drives a full 64-bit management frame on MDC and MDIO. The pin side uses an output, output-enable and input trio, so it can sit behind any tristate pad.

The command bit reads back as 1 for the whole transaction and clears by itself when the last bit has been clocked. After a read, the low half of the same word holds the data shifted in from the PHY. A separate acknowledge bit shows whether a PHY pulled the line low in the second turnaround slot. When that bit is 0, the data is not valid.

A link register holds one bit per PHY address. Each completed read of register 1 in a PHY refreshes that PHY's bit from bit 2 of the returned data. A read that is not acknowledged clears the bit.

Top module: `mdio_user_ctrl`

## Requirements
- R1: After reset the control, user-access and link registers read 0, MDC is low and the MDIO output enable is low.
- R2: Control register (select 0): bit 30 is enable, bits DIV_W-1:0 are the divider, and bit 31 reads 1 exactly when enable is set and no transaction is running.
- R3: Writing the user-access register (select 1) with bit 31 set while enabled starts a transaction. Bit 31 then reads 1 for exactly 128*(divider+1) clock cycles and returns to 0.
- R4: During a transaction MDC has a high phase and a low phase of divider+1 clock cycles each. MDC is low whenever no transaction runs.
- R5: The frame has 32 ones, start 01, opcode 10 (read) or 01 (write), a 5-bit PHY address, a 5-bit register number, a turnaround and 16 data bits, each field MSB first. On writes the turnaround is 10 and the data comes from bits 15:0.
- R6: On reads the output enable is low from the first turnaround bit to the end. Bit 29 (acknowledge) is set when MDIO is low in the second turnaround bit, and bits 15:0 then hold the 16 bits sampled on the rising MDC edges.
- R7: A read that finds MDIO high in the second turnaround bit leaves acknowledge at 0.
- R8: A write to the user-access register while a transaction runs, or while enable is clear, has no effect on the register or on the pins.
- R9: Link register (select 2): bit p takes the value acknowledge AND data bit 2 at the end of every read of register 1 at PHY address p. No other event changes it.
- R10: The user-access register reads back as: bit 31 busy, bit 30 write select, bit 29 acknowledge, bits 25:21 register number, bits 20:16 PHY address, bits 15:0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 user access, 2 link |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input (pad value) |

## Verification
The hardest case to reach is the handover in the turnaround. The master must release the line exactly when the PHY may begin driving, and acknowledge depends on a single sampled slot. The bench contains a bit-level PHY model that counts MDC edges. It drives low on the second turnaround slot and then shifts out its register contents, but only for the addresses it treats as populated. The bench then sweeps reads over every PHY address and several dividers. It also removes a PHY after its link bit has been set, which shows that a read without acknowledge clears the link bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int AW        = 5;
  localparam int GO_B      = 31;
  localparam int WR_B      = 30;
  localparam int ACK_B     = 29;
  localparam int REG_LSB   = 21;
  localparam int PHY_LSB   = 16;
  localparam int IDLE_B    = 31;
  localparam int EN_B      = 30;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 64;
  localparam int TA1_IDX   = 46;
  localparam int TA2_IDX   = 47;
  localparam int DAT_IDX   = 48;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_USER = 2'd1;
  localparam logic [1:0] SEL_LINK = 2'd2;
  localparam logic [AW-1:0] STAT_REG = 5'd1;
  localparam int LINK_B    = 2;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  mdc_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [15:0]   wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ack_o,
  output logic [15:0]   rdata_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] sh_q, frame_w;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, wr_q, ack_q, last;
  logic [15:0]          rd_q;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i,
                    (wr_i ? 2'b10 : 2'b11), (wr_i ? wdata_i : 16'hFFFF)};
  assign last      = idx_q == IDX_W'(FRAME_LEN - 1);
  assign done_o    = busy_q && fall_i && last;
  assign busy_o    = busy_q;
  assign ack_o     = ack_q;
  assign rdata_o   = rd_q;
  assign mdio_o    = busy_q && sh_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && (wr_q || (idx_q < IDX_W'(TA1_IDX)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      rd_q   <= '0;
    end else if (start_i) begin
      sh_q   <= frame_w;
      idx_q  <= '0;
      busy_q <= 1'b1;
      wr_q   <= wr_i;
      ack_q  <= 1'b0;
    end else if (busy_q) begin
      if (rise_i && !wr_q) begin
        if (idx_q == IDX_W'(TA2_IDX)) ack_q <= !mdio_i;
        if (idx_q >= IDX_W'(DAT_IDX)) rd_q <= {rd_q[14:0], mdio_i};
      end
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  // R6
  ack_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !start_i) |=> $stable(ack_q));
endmodule

// File: rtl/mdio_link.sv
module mdio_link #(
  parameter int N_PHY = 32,
  localparam int PW   = $clog2(N_PHY)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [PW-1:0]    phy_i,
  input  logic             up_i,
  output logic [N_PHY-1:0] link_o
);
  logic [N_PHY-1:0] link_q;

  for (genvar p = 0; p < N_PHY; p++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              link_q[p] <= 1'b0;
      else if (upd_i && (phy_i == PW'(p)))      link_q[p] <= up_i;
    end
  end

  assign link_o = link_q;

  // R9
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(link_q));
endmodule

// File: rtl/mdio_user_ctrl.sv
module mdio_user_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int N_PHY = 1 << AW;

  logic             en_q, wr_q;
  logic [DIV_W-1:0] div_q;
  logic [AW-1:0]    reg_q, phy_q;
  logic [15:0]      data_q, eng_rdata;
  logic             busy, done, ack, rise, fall, user_we, start, link_upd;
  logic [N_PHY-1:0] link;
  logic             unused_w;

  assign unused_w = ^reg_wdata_i[28:26];
  assign user_we  = reg_we_i && (reg_addr_i == SEL_USER) && en_q && !busy;
  assign start    = user_we && reg_wdata_i[GO_B];
  assign link_upd = done && !wr_q && (reg_q == STAT_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      wr_q   <= 1'b0;
      reg_q  <= '0;
      phy_q  <= '0;
      data_q <= '0;
    end else begin
      if (reg_we_i && (reg_addr_i == SEL_CTRL)) begin
        en_q  <= reg_wdata_i[EN_B];
        div_q <= reg_wdata_i[DIV_W-1:0];
      end
      if (user_we) begin
        wr_q   <= reg_wdata_i[WR_B];
        reg_q  <= reg_wdata_i[REG_LSB +: AW];
        phy_q  <= reg_wdata_i[PHY_LSB +: AW];
        data_q <= reg_wdata_i[15:0];
      end else if (done && !wr_q) begin
        data_q <= eng_rdata;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni, .start_i(start), .wr_i(reg_wdata_i[WR_B]),
    .phy_i(reg_wdata_i[PHY_LSB +: AW]), .reg_i(reg_wdata_i[REG_LSB +: AW]),
    .wdata_i(reg_wdata_i[15:0]), .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .done_o(done), .ack_o(ack), .rdata_o(eng_rdata),
    .mdio_o, .mdio_oe_o
  );

  mdio_link #(.N_PHY(N_PHY)) u_link (
    .clk_i, .rst_ni, .upd_i(link_upd), .phy_i(phy_q),
    .up_i(ack && eng_rdata[LINK_B]), .link_o(link)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_CTRL: begin
        reg_rdata_o[IDLE_B]    = en_q && !busy;
        reg_rdata_o[EN_B]      = en_q;
        reg_rdata_o[DIV_W-1:0] = div_q;
      end
      SEL_USER: begin
        reg_rdata_o[GO_B]             = busy;
        reg_rdata_o[WR_B]             = wr_q;
        reg_rdata_o[ACK_B]            = ack;
        reg_rdata_o[REG_LSB +: AW]    = reg_q;
        reg_rdata_o[PHY_LSB +: AW]    = phy_q;
        reg_rdata_o[15:0]             = data_q;
      end
      SEL_LINK: reg_rdata_o = link;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  // R3
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(en_q));
  // R8
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));
  // R6
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !wr_q && !mdio_oe_o) |=> !mdio_oe_o);
endmodule

// File: tb/mdio_user_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_user_ctrl_bench;
  localparam logic [1:0] A_CTRL = 2'd0, A_USER = 2'd1, A_LINK = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_in;
  logic        phy_oe = 1'b0, phy_bit = 1'b1;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  mdio_user_ctrl u_mdio_user_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  assign mdio_in = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  // PHY model
  logic [15:0] phy_mem [32][32];
  logic [31:0] present;
  logic [63:0] rx = '0, frame_log = '0;
  logic [15:0] dsh = '0;
  logic        hdr_rd = 1'b0;
  logic [4:0]  hp = '0, hr = '0;
  int          rcnt = 0;

  always @(posedge mdc) begin
    rx = {rx[62:0], mdio_in};
    rcnt = rcnt + 1;
    if (rcnt == 64) begin
      frame_log = rx;
      if (rx[29:28] == 2'b01 && present[rx[27:23]]) phy_mem[rx[27:23]][rx[22:18]] = rx[15:0];
    end
  end

  always @(negedge mdc) begin
    if (rcnt == 46) begin
      hdr_rd = (rx[11:10] == 2'b10);
      hp = rx[9:5];
      hr = rx[4:0];
    end else if (rcnt == 47) begin
      if (hdr_rd && present[hp]) begin
        phy_oe = 1'b1;
        phy_bit = 1'b0;
        dsh = phy_mem[hp][hr];
      end
    end else if (rcnt >= 48 && rcnt <= 63) begin
      phy_bit = dsh[63 - rcnt];
    end else if (rcnt == 64) begin
      phy_oe = 1'b0;
      phy_bit = 1'b1;
      rcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ureg(input bit go, input bit wr, input bit ack,
                                       input logic [4:0] r, input logic [4:0] p, input logic [15:0] d);
    return {go, wr, ack, 3'b000, r, p, d};
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
    logic [1:0]  ta;
    logic [15:0] dv;
    if (wr) begin ta = 2'b10; dv = d; end
    else if (present[p]) begin ta = 2'b10; dv = phy_mem[p][r]; end
    else begin ta = 2'b11; dv = 16'hFFFF; end
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, ta, dv};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd_reg(A_USER, v);
    while (v[31] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      rd_reg(A_USER, v);
    end
  endtask

  task automatic txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d, output int cyc);
    wr_reg(A_USER, ureg(1'b1, wr, 1'b0, r, p, d));
    wait_done(cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_link;
    logic [63:0] exp_f;
    int cyc, h, l, d, lp;
    logic [4:0] p, r;
    logic [15:0] dat;
    bit found;

    for (int i = 0; i < 32; i++) begin
      present[i] = (i % 3) != 2;
      for (int j = 0; j < 32; j++) phy_mem[i][j] = 16'((i * 1153 + j * 97 + 16'h3C5A) & 16'hFFFF);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(A_CTRL, v); chk(v == 32'h0, "R1 ctrl", v, 0);
    rd_reg(A_USER, v); chk(v == 32'h0, "R1 user", v, 0);
    rd_reg(A_LINK, v); chk(v == 32'h0, "R1 link", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    for (int k = 0; k < 3; k++) begin
      d = (k == 2) ? 3 : k;
      wr_reg(A_CTRL, 32'h4000_0000 | d);
      rd_reg(A_CTRL, v);
      chk(v == (32'hC000_0000 | d), "R2 ctrl readback", v, 32'hC000_0000 | d);
      p = 5'(4 + 3 * k); r = 5'(7 + 9 * k); dat = 16'hA5C3 ^ 16'(k * 16'h1111);

      txn(1'b1, p, r, dat, cyc);
      chk(cyc == 128 * (d + 1), "R3 write duration", cyc, 128 * (d + 1));
      exp_f = exp_frame(1'b1, p, r, dat);
      chk(frame_log == exp_f, "R5 write frame", frame_log, exp_f);
      rd_reg(A_USER, v);
      chk(v == ureg(0, 1, 0, r, p, dat), "R10 write readback", v, ureg(0, 1, 0, r, p, dat));

      txn(1'b0, p, r, 16'h0, cyc);
      chk(cyc == 128 * (d + 1), "R3 read duration", cyc, 128 * (d + 1));
      exp_f = exp_frame(1'b0, p, r, 16'h0);
      chk(frame_log == exp_f, "R5 read frame", frame_log, exp_f);
      rd_reg(A_USER, v);
      chk(v == ureg(0, 0, 1, r, p, dat), "R6 read ack and data", v, ureg(0, 0, 1, r, p, dat));

      p = 5'(2 + 3 * k);
      txn(1'b0, p, r, 16'h0, cyc);
      exp_f = exp_frame(1'b0, p, r, 16'h0);
      chk(frame_log == exp_f, "R7 absent frame", frame_log, exp_f);
      rd_reg(A_USER, v);
      chk(v[29] == 1'b0, "R7 no ack", v[29], 0);

      wr_reg(A_USER, ureg(1, 0, 0, 5'd3, 5'd1, 16'h0));
      rd_reg(A_CTRL, v);
      chk(v[31] == 1'b0, "R2 idle low while busy", v[31], 0);
      h = 0; l = 0;
      while (!mdc) @(negedge clk);
      while (mdc) begin h++; @(negedge clk); end
      while (!mdc) begin l++; @(negedge clk); end
      chk(h == d + 1, "R4 mdc high phase", h, d + 1);
      chk(l == d + 1, "R4 mdc low phase", l, d + 1);
      wait_done(cyc);
      rd_reg(A_CTRL, v);
      chk(v[31] == 1'b1, "R2 idle after done", v[31], 1);
      chk(!mdc, "R4 mdc low idle", mdc, 0);
    end

    // R8 write while busy
    wr_reg(A_CTRL, 32'h4000_0001);
    wr_reg(A_USER, ureg(1, 1, 0, 5'd5, 5'd4, 16'h1357));
    repeat (30) @(negedge clk);
    wr_reg(A_USER, ureg(1, 0, 0, 5'd9, 5'd7, 16'hFFFF));
    wait_done(cyc);
    exp_f = exp_frame(1'b1, 5'd4, 5'd5, 16'h1357);
    chk(frame_log == exp_f, "R8 busy write frame", frame_log, exp_f);
    rd_reg(A_USER, v);
    chk(v == ureg(0, 1, 0, 5'd5, 5'd4, 16'h1357), "R8 busy write readback", v, ureg(0, 1, 0, 5'd5, 5'd4, 16'h1357));
    repeat (5) @(negedge clk);
    rd_reg(A_USER, v);
    chk(v[31] == 1'b0 && !mdc, "R8 no second start", {v[31], mdc}, 0);

    // R8 disabled
    wr_reg(A_CTRL, 32'h0000_0001);
    wr_reg(A_USER, ureg(1, 0, 0, 5'd3, 5'd1, 16'h0));
    rd_reg(A_USER, v);
    chk(v == ureg(0, 1, 0, 5'd5, 5'd4, 16'h1357), "R8 disabled write ignored", v, ureg(0, 1, 0, 5'd5, 5'd4, 16'h1357));
    h = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) h++;
    end
    chk(h == 0, "R8 pins quiet when disabled", h, 0);
    rd_reg(A_CTRL, v);
    chk(v == 32'h0000_0001, "R2 idle low when disabled", v, 32'h1);

    // R9 link sweep
    wr_reg(A_CTRL, 32'h4000_0000);
    exp_link = '0;
    for (int i = 0; i < 32; i++) begin
      txn(1'b0, 5'(i), 5'd1, 16'h0, cyc);
      exp_link[i] = present[i] && phy_mem[i][1][2];
      rd_reg(A_LINK, v);
      chk(v == exp_link, "R9 link after read", v, exp_link);
    end
    found = 1'b0; lp = 0;
    for (int i = 0; i < 32; i++) if (!found && exp_link[i]) begin found = 1'b1; lp = i; end
    chk(found, "R9 linked phy exists", found, 1);
    txn(1'b0, 5'(lp), 5'd2, 16'h0, cyc);
    rd_reg(A_LINK, v);
    chk(v == exp_link, "R9 other register no effect", v, exp_link);
    present[lp] = 1'b0;
    txn(1'b0, 5'(lp), 5'd1, 16'h0, cyc);
    exp_link[lp] = 1'b0;
    rd_reg(A_LINK, v);
    chk(v == exp_link, "R9 unacked read clears", v, exp_link);
    present[lp] = 1'b1;
    txn(1'b1, 5'(lp), 5'd1, 16'h0000, cyc);
    txn(1'b0, 5'(lp), 5'd1, 16'h0, cyc);
    rd_reg(A_LINK, v);
    chk(v == exp_link, "R9 link bit low data", v, exp_link);
    txn(1'b1, 5'(lp), 5'd1, 16'h0004, cyc);
    txn(1'b0, 5'(lp), 5'd1, 16'h0, cyc);
    exp_link[lp] = 1'b1;
    rd_reg(A_LINK, v);
    chk(v == exp_link, "R9 link bit set again", v, exp_link);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule